// File: doc/BRIEF.md
# Split-Transaction Bus Request Tracker

This block is the table of outstanding transactions inside one node's bus controller on a split-transaction bus. The processor side offers a bus command and a line address. In the same cycle the tracker decides one of three outcomes:

- It accepts the request.
- It blocks the request because that line already has a transaction in flight.
- It NACKs the request because every tag is in use.

Reads and exclusive reads that are accepted take the lowest free tag. Their data returns later on the response bus as several beats, each carrying the tag. Beats for different tags may arrive in any order and may interleave. When the last beat of a tag arrives, the tracker presents the assembled line with its command and address, and the tag becomes free again.

Upgrades and writebacks have no response phase. Once accepted they complete to the processor on the next cycle and never occupy a tag. A beat whose tag has no outstanding entry is reported as an error and changes nothing. A request that is blocked or NACKed leaves the table untouched, and the processor must offer it again later.

Top module: `split_req_tracker`

## Requirements
- R1: After reset the table is empty. `fillValid`, `cplValid` and `rspErr` are low, and the first data request is given tag 0.
- R2: A read (`reqCmd`=2'b00) or exclusive read (2'b01) with no line conflict and a free tag gets `reqAccept`=1 in the same cycle. `reqTag` is the lowest-numbered free tag.
- R3: A request of any command whose `reqAddr` equals the address of an outstanding entry gets `reqBlock`=1, with `reqAccept`=0 and `reqNack`=0, and it changes no state. A conflict takes priority over a full table.
- R4: When all NTAGS entries are in use, a read or exclusive read without a conflict gets `reqNack`=1 and `reqAccept`=0.
- R5: An upgrade (2'b11 is writeback, 2'b10 is upgrade) without a conflict is accepted even when the table is full and takes no tag. `cplValid` pulses for one cycle in the cycle after acceptance, carrying that command and address.
- R6: Response beats arriving for a tag fill the line in arrival order: the k-th beat (counting from 0) lands in bits [k*DATA_W +: DATA_W]. In the cycle after the final beat (LINE_BYTES*8/DATA_W beats), `fillValid` pulses with the tag, command, address and complete line.
- R7: Beats of different tags may interleave and complete out of request order. Each tag's line is assembled independently.
- R8: A tag becomes free at its final beat. From the next cycle it can be allocated again, and its address no longer blocks.
- R9: A beat whose tag has no outstanding entry raises `rspErr` in the next cycle, produces no fill, and changes no entry.
- R10: While `reqValid` is low, `reqAccept`, `reqNack` and `reqBlock` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered this cycle |
| reqCmd | input | 2 | 00 read, 01 exclusive read, 10 upgrade, 11 writeback |
| reqAddr | input | ADDR_W | Line address of the request |
| reqAccept | output | 1 | Request accepted this cycle |
| reqNack | output | 1 | Request refused: no free tag |
| reqBlock | output | 1 | Request refused: line already outstanding |
| reqTag | output | TAG_W | Tag given to an accepted data request |
| rspValid | input | 1 | Response beat present |
| rspTag | input | TAG_W | Tag of the response beat |
| rspData | input | DATA_W | Beat payload |
| fillValid | output | 1 | Completed line available (one cycle) |
| fillTag | output | TAG_W | Tag of the completed line |
| fillCmd | output | 2 | Command of the completed line |
| fillAddr | output | ADDR_W | Address of the completed line |
| fillLine | output | LINE_BYTES*8 | Assembled line |
| cplValid | output | 1 | Upgrade or writeback completed (one cycle) |
| cplCmd | output | 2 | Command that completed |
| cplAddr | output | ADDR_W | Address that completed |
| rspErr | output | 1 | Beat arrived for a tag with no entry |

## Verification
The bench uses the default parameters: eight tags, 256-bit beats and 128-byte lines, which gives four beats per line. With eight tags the bench can fill the whole table in a few requests, so it reaches NACK, priority of conflict over full, and tag reuse in the middle of the table. Four beats per line leave room to interleave two tags beat by beat, and to drain all eight tags in reverse order.

// File: rtl/split_req_tracker_pkg.sv
package split_req_tracker_pkg;

  localparam logic [1:0] CMD_RD  = 2'b00;
  localparam logic [1:0] CMD_RDX = 2'b01;
  localparam logic [1:0] CMD_UPG = 2'b10;
  localparam logic [1:0] CMD_WB  = 2'b11;

  // strobes from the control to the line datapath
  typedef struct packed {
    logic beatWr;    // store one response beat
    logic lineDone;  // this beat is the final one: publish the line
  } dpStrobe_t;

  // commands with bit 1 clear wait for a data response and hold a tag
  function automatic logic needsTag(input logic [1:0] cmd);
    return !cmd[1];
  endfunction

endpackage

// File: rtl/split_req_tracker_ctrl.sv
module split_req_tracker_ctrl
  import split_req_tracker_pkg::*;
#(
  parameter int NTAGS  = 8,
  parameter int ADDR_W = 26,
  parameter int BEATS  = 4,
  localparam int TAG_W  = (NTAGS > 1) ? $clog2(NTAGS) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqAccept,
  output logic              reqNack,
  output logic              reqBlock,
  output logic [TAG_W-1:0]  reqTag,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag,
  output dpStrobe_t         stb,
  output logic [TAG_W-1:0]  dpTag,
  output logic [BEAT_W-1:0] dpBeat,
  output logic              fillValid,
  output logic [TAG_W-1:0]  fillTag,
  output logic [1:0]        fillCmd,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              cplValid,
  output logic [1:0]        cplCmd,
  output logic [ADDR_W-1:0] cplAddr,
  output logic              rspErr
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [NTAGS-1:0]  validQ;
  logic [ADDR_W-1:0] addrQ [NTAGS];
  logic [1:0]        cmdQ  [NTAGS];
  logic [BEAT_W-1:0] beatQ [NTAGS];

  // line-address match against every live entry
  logic [NTAGS-1:0] hitVec;
  for (genvar gi = 0; gi < NTAGS; gi++) begin : g_match
    assign hitVec[gi] = validQ[gi] && (addrQ[gi] == reqAddr);
  end

  // lowest free tag
  logic [TAG_W-1:0] freeTag;
  logic             haveFree;
  always_comb begin
    freeTag  = '0;
    haveFree = 1'b0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeTag  = TAG_W'(i);
        haveFree = 1'b1;
      end
    end
  end

  logic anyHit, wantTag, allocEn;
  assign anyHit    = |hitVec;
  assign wantTag   = needsTag(reqCmd);
  assign reqBlock  = reqValid && anyHit;
  assign reqNack   = reqValid && !anyHit && wantTag && !haveFree;
  assign reqAccept = reqValid && !anyHit && (!wantTag || haveFree);
  assign reqTag    = freeTag;
  assign allocEn   = reqAccept && wantTag;

  logic rspHit, rspLast;
  assign rspHit = rspValid && validQ[rspTag];
  assign rspLast = rspHit && (beatQ[rspTag] == LAST_BEAT);

  assign stb.beatWr   = rspHit;
  assign stb.lineDone = rspLast;
  assign dpTag        = rspTag;
  assign dpBeat       = beatQ[rspTag];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ    <= '0;
      fillValid <= 1'b0;
      cplValid  <= 1'b0;
      rspErr    <= 1'b0;
      for (int i = 0; i < NTAGS; i++) beatQ[i] <= '0;
    end else begin
      if (allocEn) begin
        validQ[freeTag] <= 1'b1;
        beatQ[freeTag]  <= '0;
      end
      if (rspHit) begin
        if (rspLast) begin
          validQ[rspTag] <= 1'b0;
          beatQ[rspTag]  <= '0;
        end else begin
          beatQ[rspTag] <= beatQ[rspTag] + BEAT_W'(1);
        end
      end
      fillValid <= rspLast;
      cplValid  <= reqAccept && !wantTag;
      rspErr    <= rspValid && !validQ[rspTag];
    end
  end

  // payload registers carry no reset; they are qualified by the valids
  always_ff @(posedge clk) begin
    if (allocEn) begin
      addrQ[freeTag] <= reqAddr;
      cmdQ[freeTag]  <= reqCmd;
    end
    fillTag  <= rspTag;
    fillCmd  <= cmdQ[rspTag];
    fillAddr <= addrQ[rspTag];
    cplCmd   <= reqCmd;
    cplAddr  <= reqAddr;
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(reqAccept || reqNack || reqBlock));

  // R3
  block_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqBlock |-> !reqAccept && !reqNack);

  // R4
  nack_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqNack |-> (&validQ));

  // R2
  alloc_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && needsTag(reqCmd)) |=> validQ[$past(reqTag)]);

  // R5
  cpl_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && !needsTag(reqCmd)) |=> cplValid);

  // R8
  fill_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> !validQ[fillTag]);

  // R9
  orphan_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !validQ[rspTag]) |=> rspErr && !fillValid);

endmodule

// File: rtl/split_req_tracker_data.sv
module split_req_tracker_data
  import split_req_tracker_pkg::*;
#(
  parameter int NTAGS  = 8,
  parameter int DATA_W = 256,
  parameter int BEATS  = 4,
  localparam int TAG_W  = (NTAGS > 1) ? $clog2(NTAGS) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LINE_W = DATA_W * BEATS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [TAG_W-1:0]  dpTag,
  input  logic [BEAT_W-1:0] dpBeat,
  input  logic [DATA_W-1:0] rspData,
  output logic [LINE_W-1:0] fillLine
);

  logic [DATA_W-1:0] bufQ [NTAGS][BEATS];
  logic [LINE_W-1:0] lineNow;

  // earlier beats come from the buffer, the final beat straight from the bus
  for (genvar gb = 0; gb < BEATS; gb++) begin : g_line
    if (gb == BEATS - 1) begin : g_last
      assign lineNow[gb*DATA_W +: DATA_W] = rspData;
    end else begin : g_buf
      assign lineNow[gb*DATA_W +: DATA_W] = bufQ[dpTag][gb];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.beatWr) bufQ[dpTag][dpBeat] <= rspData;
    if (stb.lineDone) fillLine <= lineNow;
  end

  // R6
  done_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lineDone |-> stb.beatWr && (dpBeat == BEAT_W'(BEATS - 1)));

endmodule

// File: rtl/split_req_tracker.sv
module split_req_tracker
  import split_req_tracker_pkg::*;
#(
  parameter int NTAGS      = 8,
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 256,
  parameter int LINE_BYTES = 128,
  localparam int TAG_W  = (NTAGS > 1) ? $clog2(NTAGS) : 1,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int BEATS  = LINE_W / DATA_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqAccept,
  output logic              reqNack,
  output logic              reqBlock,
  output logic [TAG_W-1:0]  reqTag,
  input  logic              rspValid,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  output logic              fillValid,
  output logic [TAG_W-1:0]  fillTag,
  output logic [1:0]        fillCmd,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LINE_W-1:0] fillLine,
  output logic              cplValid,
  output logic [1:0]        cplCmd,
  output logic [ADDR_W-1:0] cplAddr,
  output logic              rspErr
);

  dpStrobe_t         stb;
  logic [TAG_W-1:0]  dpTag;
  logic [BEAT_W-1:0] dpBeat;

  split_req_tracker_ctrl #(
    .NTAGS(NTAGS), .ADDR_W(ADDR_W), .BEATS(BEATS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqAccept(reqAccept), .reqNack(reqNack), .reqBlock(reqBlock), .reqTag(reqTag),
    .rspValid(rspValid), .rspTag(rspTag),
    .stb(stb), .dpTag(dpTag), .dpBeat(dpBeat),
    .fillValid(fillValid), .fillTag(fillTag), .fillCmd(fillCmd), .fillAddr(fillAddr),
    .cplValid(cplValid), .cplCmd(cplCmd), .cplAddr(cplAddr),
    .rspErr(rspErr)
  );

  split_req_tracker_data #(
    .NTAGS(NTAGS), .DATA_W(DATA_W), .BEATS(BEATS)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .stb(stb), .dpTag(dpTag), .dpBeat(dpBeat),
    .rspData(rspData), .fillLine(fillLine)
  );

endmodule

// File: tb/tb_split_req_tracker.sv
`timescale 1ns/100ps
module tb_split_req_tracker;

  localparam int NT = 8, AW = 26, DW = 256, LB = 128;
  localparam int LW = LB * 8, BEATS = LW / DW, TW = 3;
  localparam logic [1:0] RD = 2'b00, RDX = 2'b01, UPG = 2'b10, WB = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCmd = '0;
  logic [AW-1:0] reqAddr = '0;
  logic reqAccept, reqNack, reqBlock;
  logic [TW-1:0] reqTag;
  logic rspValid = 1'b0;
  logic [TW-1:0] rspTag = '0;
  logic [DW-1:0] rspData = '0;
  logic fillValid, cplValid, rspErr;
  logic [TW-1:0] fillTag;
  logic [1:0] fillCmd, cplCmd;
  logic [AW-1:0] fillAddr, cplAddr;
  logic [LW-1:0] fillLine;

  always #2.5 clk = ~clk;

  split_req_tracker #(.NTAGS(NT), .ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqAccept(reqAccept), .reqNack(reqNack), .reqBlock(reqBlock), .reqTag(reqTag),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData),
    .fillValid(fillValid), .fillTag(fillTag), .fillCmd(fillCmd), .fillAddr(fillAddr),
    .fillLine(fillLine),
    .cplValid(cplValid), .cplCmd(cplCmd), .cplAddr(cplAddr),
    .rspErr(rspErr)
  );

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  typedef struct {
    logic [TW-1:0] tag;
    logic [AW-1:0] addr;
    logic [1:0]    cmd;
    logic [LW-1:0] line;
  } fillItem_t;
  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    cmd;
  } cplItem_t;

  fillItem_t fillQ[$];
  cplItem_t  cplQ[$];
  fillItem_t fExp;
  cplItem_t  cExp;

  // bench-side model of each tag's entry
  logic [AW-1:0] mAddr[NT];
  logic [1:0]    mCmd[NT];
  int            mBeat[NT];
  logic [LW-1:0] mLine[NT];

  task automatic doReq(input logic [1:0] cmd, input logic [AW-1:0] addr,
                       input bit eAcc, input bit eNack, input bit eBlk,
                       input int eTag, input string r);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqAddr = addr;
    #1;
    chk(reqAccept == eAcc, r, "accept", 64'(reqAccept), 64'(eAcc));
    chk(reqNack == eNack, r, "nack", 64'(reqNack), 64'(eNack));
    chk(reqBlock == eBlk, r, "block", 64'(reqBlock), 64'(eBlk));
    if (eAcc && !cmd[1])
      chk(reqTag == TW'(eTag), r, "tag", 64'(reqTag), 64'(eTag));
    if (eAcc) begin
      if (cmd[1]) cplQ.push_back('{addr: addr, cmd: cmd});
      else begin
        mAddr[eTag] = addr; mCmd[eTag] = cmd; mBeat[eTag] = 0; mLine[eTag] = '0;
      end
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic doBeat(input int tag, input logic [15:0] salt);
    logic [DW-1:0] w;
    w = {8{salt, 8'(tag), 8'(mBeat[tag])}};
    @(negedge clk);
    rspValid = 1'b1; rspTag = TW'(tag); rspData = w;
    mLine[tag][mBeat[tag]*DW +: DW] = w;
    mBeat[tag]++;
    if (mBeat[tag] == BEATS)
      fillQ.push_back('{tag: TW'(tag), addr: mAddr[tag], cmd: mCmd[tag], line: mLine[tag]});
    @(posedge clk);
    #1 rspValid = 1'b0;
  endtask

  // scoreboard monitor: completed lines and completions, in expected order
  always @(negedge clk) begin
    if (rstN) begin
      if (fillValid) begin
        if (fillQ.size() == 0) chk(1'b0, "R6", "unexpected fill tag", 64'(fillTag), 64'(0));
        else begin
          fExp = fillQ.pop_front();
          chk(fillTag == fExp.tag, "R7", "fill tag", 64'(fillTag), 64'(fExp.tag));
          chk(fillAddr == fExp.addr, "R6", "fill addr", 64'(fillAddr), 64'(fExp.addr));
          chk(fillCmd == fExp.cmd, "R6", "fill cmd", 64'(fillCmd), 64'(fExp.cmd));
          chk(fillLine == fExp.line, "R6", "fill line low64", fillLine[63:0], fExp.line[63:0]);
        end
      end
      if (cplValid) begin
        if (cplQ.size() == 0) chk(1'b0, "R5", "unexpected cpl addr", 64'(cplAddr), 64'(0));
        else begin
          cExp = cplQ.pop_front();
          chk(cplAddr == cExp.addr, "R5", "cpl addr", 64'(cplAddr), 64'(cExp.addr));
          chk(cplCmd == cExp.cmd, "R5", "cpl cmd", 64'(cplCmd), 64'(cExp.cmd));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    chk(fillValid == 1'b0, "R1", "fillValid", 64'(fillValid), 64'(0));
    chk(cplValid == 1'b0, "R1", "cplValid", 64'(cplValid), 64'(0));
    chk(rspErr == 1'b0, "R1", "rspErr", 64'(rspErr), 64'(0));

    doReq(RD,  26'h100, 1, 0, 0, 0, "R1");
    doReq(RDX, 26'h200, 1, 0, 0, 1, "R2");
    doReq(RD,  26'h100, 0, 0, 1, 0, "R3");
    doReq(UPG, 26'h300, 1, 0, 0, 0, "R5");
    doReq(UPG, 26'h200, 0, 0, 1, 0, "R3");

    // R10: nothing acknowledged without reqValid
    @(negedge clk);
    reqValid = 1'b0; reqCmd = RD; reqAddr = 26'h500;
    #1;
    chk(!(reqAccept || reqNack || reqBlock), "R10", "idle handshake",
        {61'b0, reqAccept, reqNack, reqBlock}, 64'(0));

    // R7: interleave beats, tag 1 completes before tag 0
    doBeat(1, 16'hA1); doBeat(0, 16'hB0); doBeat(1, 16'hA1);
    doBeat(1, 16'hA1); doBeat(0, 16'hB0); doBeat(1, 16'hA1);

    // R8: tag 1 freed, same line accepted again with tag 1
    doReq(RDX, 26'h200, 1, 0, 0, 1, "R8");

    // R9: beat for a tag with no entry
    @(negedge clk);
    rspValid = 1'b1; rspTag = 3'd5; rspData = '1;
    @(posedge clk);
    #1 rspValid = 1'b0;
    chk(rspErr == 1'b1, "R9", "rspErr", 64'(rspErr), 64'(1));
    chk(fillValid == 1'b0, "R9", "no fill", 64'(fillValid), 64'(0));

    doBeat(0, 16'hB0); doBeat(0, 16'hB0);
    for (int k = 0; k < BEATS; k++) doBeat(1, 16'hC1);
    repeat (2) @(posedge clk);

    // fill the whole table
    for (int i = 0; i < NT; i++) doReq(RD, 26'h400 + 26'(i), 1, 0, 0, i, "R2");
    doReq(RD,  26'h900, 0, 1, 0, 0, "R4");
    doReq(RDX, 26'h901, 0, 1, 0, 0, "R4");
    doReq(RD,  26'h403, 0, 0, 1, 0, "R3");
    doReq(WB,  26'h950, 1, 0, 0, 0, "R5");
    doReq(UPG, 26'h404, 0, 0, 1, 0, "R3");

    // free tag 3 out of order, then it is the lowest free
    for (int k = 0; k < BEATS; k++) doBeat(3, 16'hD3);
    doReq(RD, 26'hA00, 1, 0, 0, 3, "R2");
    doReq(RD, 26'hA01, 0, 1, 0, 0, "R4");

    // R7: drain in reverse tag order
    for (int t = NT - 1; t >= 0; t--)
      for (int k = 0; k < BEATS; k++) doBeat(t, 16'hE0 + 16'(t));
    repeat (3) @(posedge clk);
    #1;
    chk(fillQ.size() == 0, "R6", "fills outstanding", 64'(fillQ.size()), 64'(0));
    chk(cplQ.size() == 0, "R5", "cpls outstanding", 64'(cplQ.size()), 64'(0));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule